// File: doc/BRIEF.md
# Dual Countdown Timer with Shared Interrupt

The block holds two independent down-counters behind a word-wide register port. The two counters share one interrupt line. Each channel has three registers: a reload register, which holds the divider value; a live count register, which is read-only; and a control register. The control register carries a two-bit operation code and a three-bit tick-source field. Tick sources arrive on `tick_in` as single-cycle enable pulses. Each of the four rate inputs is picked by one source code. The other codes leave the counter frozen.

Each channel is a two-state machine. Its states are `CH_STOP` and `CH_RUN`.
- Reset forces `CH_STOP`.
- A control write with the run code takes the transition named `GO_RUN`, from either state into `CH_RUN`.
- A control write with the load, hold or illegal code takes `GO_STOP` into `CH_STOP`.
- With no control write, each state stays where it is (`STAY`).

In `CH_RUN`, every selected tick either decrements the count or, at the end of the period, reloads it and raises a one-cycle expiry pulse. The shared interrupt section keeps the expiry events as raw status bits. It offers a mask, a write-one acknowledge and a masked view, and it drives `irq_o` from the registered raw and mask bits.

Top module: `dtmr_top`

## Requirements
- R1: A control write with operation code 0 in bits [1:0] loads the channel's divider value into its count and leaves the channel in `CH_STOP`.
- R2: Operation code 1 (hold) and code 3 (illegal) stop the channel, and the count does not change on any later tick.
- R3: Control bits [4:2] pick the tick source. Values 4, 5, 6 and 7 select `tick_in[0]`, `tick_in[1]`, `tick_in[2]` and `tick_in[3]`. Values 0 to 3 select no source, so a running counter does not advance.
- R4: A write to a divider register (channel 0 at 0x00, channel 1 at 0x10) only stores the value, which reads back at that offset. The value reaches the count or the reload only through a later load or run control write (control at 0x08 and 0x18).
- R5: In `CH_RUN`, each pulse on the selected tick lowers the count (channel 0 at 0x04, channel 1 at 0x14) by one while the count is above 1.
- R6: A selected tick in `CH_RUN` while the count is 1 or 0 reloads the count from the divider value captured at the last load or run write. It gives a one-cycle expiry and the channel keeps running.
- R7: An expiry of channel 0 sets raw status bit 0, and an expiry of channel 1 sets bit 1. The raw status reads at 0x50.
- R8: A write to 0x4C clears each raw bit where the written data has a 1 and leaves the others. The offset reads as zero. An expiry in the same cycle wins over the clear.
- R9: The masked status at 0x54 equals raw AND mask (mask at 0x48). `irq_o` is high exactly when a masked bit is set, from the cycle after a mask, acknowledge or expiry update.
- R10: Reset puts both channels in `CH_STOP` with a zero count and clears the raw status and the mask, so `irq_o` is low.
- R11: Reads of any other offset return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for one word |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_in | input | 4 | Rate enable pulses, one per source |
| irq_o | output | 1 | Shared interrupt, high while a masked bit is set |

## Verification
A channel stuck in the wrong state shows on the first selected tick after the control write. Either the count register fails to move when it should, or it moves when it should not, and the read on the next cycle exposes it. A wrong reload or expiry shows as a wrong count one cycle after the period ends. It also shows as a raw bit at 0x50 that is missing or set for no reason on the same cycle. A fault in the mask or acknowledge path shows on `irq_o` and on 0x54 one clock after the offending write.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } op_e;

    typedef enum logic {
        CH_STOP = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    localparam int CH_STRIDE = 16;
    localparam int OFS_DIV   = 0;
    localparam int OFS_CNT   = 4;
    localparam int OFS_CTRL  = 8;
    localparam int OFS_MASK  = 'h48;
    localparam int OFS_ACK   = 'h4C;
    localparam int OFS_RAW   = 'h50;
    localparam int OFS_MSKD  = 'h54;

endpackage

// File: rtl/dtmr_tick_sel.sv
module dtmr_tick_sel #(
    parameter int N_RATE = 4,
    parameter int SEL_W  = 3
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [N_RATE-1:0] tick_in,
    output logic              tick
);
    // Source codes N_RATE .. 2*N_RATE-1 map to the rate inputs; lower codes give no tick.
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < N_RATE; i++) begin
            if (sel == SEL_W'(N_RATE + i)) begin
                tick = tick_in[i];
            end
        end
    end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  op_e              ctrl_op,
    input  logic [CNT_W-1:0] div_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire
);
    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             step;
    logic             at_end;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: GO_RUN, GO_STOP or STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOP: begin
                if (ctrl_we && ctrl_op == OP_RUN) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (ctrl_we && ctrl_op != OP_RUN) state_d = CH_STOP;
            end
        endcase
    end

    // Outputs
    always_comb begin
        running = (state_q == CH_RUN);
        step    = running && tick && !ctrl_we;
        at_end  = (cnt_q <= CNT_W'(1));
        expire  = step && at_end;
        count   = cnt_q;
    end

    // Count and reload datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
        end else if (ctrl_we) begin
            if (ctrl_op == OP_LOAD) begin
                cnt_q    <= div_val;
                reload_q <= div_val;
            end else if (ctrl_op == OP_RUN) begin
                reload_q <= div_val;
            end
        end else if (step) begin
            cnt_q <= at_end ? reload_q : cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mask_we,
    input  logic           ack_we,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] expire,
    output logic [NCH-1:0] raw,
    output logic [NCH-1:0] mask,
    output logic           irq
);
    logic [NCH-1:0] raw_q, mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~(ack_we ? wbits : '0)) | expire;
            if (mask_we) mask_q <= wbits;
        end
    end

    always_comb begin
        raw  = raw_q;
        mask = mask_q;
        irq  = |(raw_q & mask_q);
    end
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int NCH    = 2,
    parameter int N_RATE = 4,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_RATE-1:0] tick_in,
    output logic              irq_o
);
    localparam int CTRL_W = SEL_W + 2;

    logic [DATA_W-1:0] div_q  [NCH];
    logic [CTRL_W-1:0] ctrl_q [NCH];
    logic [DATA_W-1:0] cnt_w  [NCH];
    logic [NCH-1:0]    exp_w;
    logic [NCH-1:0]    run_w;
    logic [NCH-1:0]    raw_w;
    logic [NCH-1:0]    mask_w;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(g * CH_STRIDE + OFS_DIV);
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(g * CH_STRIDE + OFS_CTRL);
        logic div_we, ctrl_we, tick;

        assign div_we  = bus_we && (bus_addr == A_DIV);
        assign ctrl_we = bus_we && (bus_addr == A_CTRL);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                div_q[g]  <= '0;
                ctrl_q[g] <= CTRL_W'(OP_HOLD);
            end else begin
                if (div_we)  div_q[g]  <= bus_wdata;
                if (ctrl_we) ctrl_q[g] <= bus_wdata[CTRL_W-1:0];
            end
        end

        dtmr_tick_sel #(.N_RATE(N_RATE), .SEL_W(SEL_W)) u_sel (
            .sel     (ctrl_q[g][CTRL_W-1:2]),
            .tick_in (tick_in),
            .tick    (tick)
        );

        dtmr_channel #(.CNT_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we),
            .ctrl_op (op_e'(bus_wdata[1:0])),
            .div_val (div_q[g]),
            .tick    (tick),
            .count   (cnt_w[g]),
            .running (run_w[g]),
            .expire  (exp_w[g])
        );
    end

    dtmr_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (bus_we && bus_addr == ADDR_W'(OFS_MASK)),
        .ack_we  (bus_we && bus_addr == ADDR_W'(OFS_ACK)),
        .wbits   (bus_wdata[NCH-1:0]),
        .expire  (exp_w),
        .raw     (raw_w),
        .mask    (mask_w),
        .irq     (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(i * CH_STRIDE + OFS_DIV))  bus_rdata = div_q[i];
            if (bus_addr == ADDR_W'(i * CH_STRIDE + OFS_CNT))  bus_rdata = cnt_w[i];
            if (bus_addr == ADDR_W'(i * CH_STRIDE + OFS_CTRL)) bus_rdata = DATA_W'(ctrl_q[i]);
        end
        if (bus_addr == ADDR_W'(OFS_MASK)) bus_rdata = DATA_W'(mask_w);
        if (bus_addr == ADDR_W'(OFS_RAW))  bus_rdata = DATA_W'(raw_w);
        if (bus_addr == ADDR_W'(OFS_MSKD)) bus_rdata = DATA_W'(raw_w & mask_w);
    end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int NCH    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_o,
    input logic              exp0,
    input logic              run0,
    input logic [DATA_W-1:0] cnt0,
    input logic [DATA_W-1:0] div0,
    input logic [NCH-1:0]    raw,
    input logic [NCH-1:0]    mask
);
    logic ctrl0_we, ack_we, mask_we;
    assign ctrl0_we = bus_we && bus_addr == ADDR_W'(OFS_CTRL);
    assign ack_we   = bus_we && bus_addr == ADDR_W'(OFS_ACK);
    assign mask_we  = bus_we && bus_addr == ADDR_W'(OFS_MASK);

    // R1
    load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0_we && bus_wdata[1:0] == 2'd0) |=> (cnt0 == $past(div0) && !run0));

    // R2
    stopped_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0 && !ctrl0_we) |=> $stable(cnt0));

    // R7
    expire_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp0 |=> raw[0]);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && bus_wdata[0] && !exp0) |=> !raw[0]);

    // R9
    mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && bus_wdata[NCH-1:0] == '0) |=> !irq_o);

    // R9
    masked_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & mask) != '0) |-> irq_o);
endmodule

bind dtmr_top dtmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .exp0      (exp_w[0]),
    .run0      (run_w[0]),
    .cnt0      (cnt_w[0]),
    .div0      (div_q[0]),
    .raw       (raw_w),
    .mask      (mask_w)
);

// File: tb/dtmr_top_test.sv
`timescale 1ns/1ps
module dtmr_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_in = '0;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dtmr_top uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in), .irq_o(irq_o)
    );

    // {kind, addr, data or expected, requirement}; kind 0 write, 1 read check, 2 tick pulse
    localparam int NV = 29;
    localparam logic [45:0] VEC [0:NV-1] = '{
        {2'd0, 8'h00, 32'd3,     4'd4},  // R4 store divider
        {2'd1, 8'h04, 32'd0,     4'd4},  // R4 count untouched
        {2'd1, 8'h00, 32'd3,     4'd4},  // R4 read back
        {2'd0, 8'h08, 32'h10,    4'd1},  // R1 load, source 4
        {2'd1, 8'h04, 32'd3,     4'd1},  // R1
        {2'd0, 8'h08, 32'h12,    4'd5},  // run
        {2'd2, 8'h00, 32'h1,     4'd5},
        {2'd1, 8'h04, 32'd2,     4'd5},  // R5
        {2'd2, 8'h00, 32'h2,     4'd3},  // other rate
        {2'd1, 8'h04, 32'd2,     4'd3},  // R3
        {2'd2, 8'h00, 32'h1,     4'd5},
        {2'd2, 8'h00, 32'h1,     4'd6},  // end of period
        {2'd1, 8'h04, 32'd3,     4'd6},  // R6 reload
        {2'd1, 8'h50, 32'd1,     4'd7},  // R7 bit 0
        {2'd1, 8'h54, 32'd0,     4'd9},  // R9 mask off
        {2'd0, 8'h48, 32'd1,     4'd9},
        {2'd1, 8'h54, 32'd1,     4'd9},  // R9
        {2'd0, 8'h4C, 32'd1,     4'd8},
        {2'd1, 8'h50, 32'd0,     4'd8},  // R8 cleared
        {2'd1, 8'h4C, 32'd0,     4'd8},  // R8 reads zero
        {2'd0, 8'h10, 32'd2,     4'd4},
        {2'd0, 8'h18, 32'h1C,    4'd1},  // load, source 7
        {2'd0, 8'h18, 32'h1E,    4'd5},  // run
        {2'd2, 8'h00, 32'h8,     4'd5},
        {2'd2, 8'h00, 32'h8,     4'd6},
        {2'd1, 8'h50, 32'd2,     4'd7},  // R7 bit 1
        {2'd1, 8'h54, 32'd0,     4'd9},  // R9 bit 1 masked off
        {2'd0, 8'h18, 32'h1D,    4'd2},  // hold
        {2'd1, 8'h14, 32'd2,     4'd2}   // R2 after a hold
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input int req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, req);
    endtask

    task automatic tk(input logic [3:0] m);
        @(negedge clk);
        tick_in = m;
        @(negedge clk);
        tick_in = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        rd(8'h04, 0, 10); rd(8'h14, 0, 10); rd(8'h50, 0, 10); rd(8'h48, 0, 10);
        check({31'd0, irq_o}, 0, 10);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][45:44])
                2'd0: wr(VEC[i][43:36], VEC[i][35:4]);
                2'd1: rd(VEC[i][43:36], VEC[i][35:4], int'(VEC[i][3:0]));
                default: tk(VEC[i][7:4]);
            endcase
        end

        // R9 irq follows mask on the next cycle (raw = 2)
        check({31'd0, irq_o}, 0, 9);
        wr(8'h48, 3); check({31'd0, irq_o}, 1, 9);
        wr(8'h48, 0); check({31'd0, irq_o}, 0, 9);
        // R8 ack of unset bit leaves others
        wr(8'h4C, 1); rd(8'h50, 2, 8);
        wr(8'h4C, 2); rd(8'h50, 0, 8);
        // R2 illegal code 3 stops channel 0 (count 3)
        wr(8'h08, 32'h13); tk(4'hF); rd(8'h04, 3, 2);
        // R3 source 0 never advances
        wr(8'h08, 32'h02); tk(4'hF); rd(8'h04, 3, 3);
        // R8 expiry wins over simultaneous ack; R6 reload
        wr(8'h08, 32'h12); tk(4'h1); tk(4'h1); rd(8'h04, 1, 5);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h4C; bus_wdata = 1; tick_in = 4'h1;
        @(negedge clk);
        bus_we = 1'b0; tick_in = '0;
        rd(8'h50, 1, 8); rd(8'h04, 3, 6);
        // R11 undefined offset
        wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, 0, 11); rd(8'h04, 3, 11);
        rd(8'h48, 0, 11); rd(8'h00, 3, 11); rd(8'h50, 1, 11);
        // R10 reset while running with irq high
        wr(8'h48, 1); check({31'd0, irq_o}, 1, 9);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check({31'd0, irq_o}, 0, 10);
        rd(8'h04, 0, 10); rd(8'h50, 0, 10); rd(8'h48, 0, 10);
        tk(4'hF); rd(8'h04, 0, 10);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule